// File: doc/BRIEF.md
# Auto-Incrementing Transfer Buffer Access Port

This block holds a 512-byte transfer buffer, stored as 128 words of 32 bits, and shares it between two users. The first is a host register interface. The second is the flash sequencer that drives the serial data phases. The host sees the whole buffer through a single data register, which acts as a window onto it. A control register sets the transfer direction, switches on auto-increment of the word pointer, and loads that pointer. With auto-increment on, the host can stream a whole block with back-to-back accesses. A third register holds the byte offset at which the sequencer starts.

The sequencer works one byte at a time. It pulls bytes out of the buffer for data-out phases and pushes received bytes in for data-in phases. Its byte pointer is loaded from the base offset when a start pulse arrives, and it advances by one after each byte. Bytes are packed little-endian: byte lane 0 of a word is the first byte sent or received. When a byte count is not a multiple of four, the host makes one extra word access, and only the low-order bytes of that word carry data.

Top module: `xfer_buf_port`

## Requirements
- R1: After reset, a read of the control register (select 0) returns 0 and a read of the base register (select 2) returns 0.
- R2: A host write to the control register loads the direction from bit 31 (1 = host fills the buffer, 0 = host drains it), the auto-increment enable from bit 30, and the word pointer from bits 6:0. Bit 7 of the pointer field is dropped. A read of the control register returns these same fields at the same positions, with all other bits 0.
- R3: With the direction set to fill, a host write to the data register (select 1) stores the 32-bit word at the word pointer. If auto-increment is on, the pointer then advances by one.
- R4: With the direction set to drain, a host write to the data register is ignored: the buffer and the word pointer both stay unchanged.
- R5: A host read of the data register returns the word at the pointer on host_rdata in the cycle after the request. The pointer advances by one only if auto-increment is on, and only after the word has been captured. Reads of the control or base register never move the pointer.
- R6: The word pointer wraps from 127 to 0.
- R7: The base register (select 2, bits 8:0) holds a byte offset. A seq_start pulse loads the sequencer byte pointer from it. The host reads the offset back in bits 8:0.
- R8: A seq_rd pulse returns the byte at the sequencer pointer on seq_rbyte in the next cycle, with byte lane k taken from bits 8k+7:8k of the word. The pointer then advances by one.
- R9: A seq_wr pulse stores seq_wbyte into byte lane (pointer mod 4) of word (pointer / 4) and advances the pointer. A partial last word keeps its data in the low-order lanes.
- R10: The sequencer byte pointer wraps from 511 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| host_req | input | 1 | Host register access strobe, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_reg | input | 2 | Register select: 0 control, 1 data, 2 sequencer base |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read request |
| seq_start | input | 1 | Loads the sequencer byte pointer from the base offset |
| seq_rd | input | 1 | Sequencer byte pull for a data-out phase |
| seq_wr | input | 1 | Sequencer byte push for a data-in phase |
| seq_wbyte | input | 8 | Received byte to store |
| seq_rbyte | output | 8 | Byte pulled, valid the cycle after seq_rd |

## Verification
The bench uses the default parameters: 128 words, a 7-bit word pointer and a 9-bit byte pointer. With these values the word wrap is reached by loading pointer 127 and making two writes, and the byte wrap is reached by setting the base to 510 and pushing four bytes. The power-of-two depth lets both pointers wrap on their own, so the same sequences also exercise the buffer's last word and its first word.

// File: rtl/xfb_pkg.sv
package xfb_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_DATA = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } xfb_sel_e;
  localparam int DIR_BIT = 31;
  localparam int INC_BIT = 30;
endpackage

// File: rtl/xfb_store.sv
module xfb_store #(
  parameter int WORDS  = 128,
  parameter int PTR_W  = 7,
  parameter int BPTR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              h_we,
  input  logic              h_re,
  input  logic [PTR_W-1:0]  h_idx,
  input  logic [31:0]       h_wdata,
  output logic [31:0]       h_rword,
  input  logic              s_we,
  input  logic              s_re,
  input  logic [BPTR_W-1:0] s_bptr,
  input  logic [7:0]        s_wbyte,
  output logic [31:0]       s_rword
);
  logic [31:0]      mem [WORDS];
  logic [PTR_W-1:0] s_widx;
  logic [1:0]       s_lane;
  logic             s_clash;

  always_comb begin
    s_widx  = s_bptr[BPTR_W-1:2];
    s_lane  = s_bptr[1:0];
    s_clash = h_we && (h_idx == s_widx);
  end

  // storage array, no reset; host word write wins a same-word collision
  always_ff @(posedge clk) begin
    if (h_we) mem[h_idx] <= h_wdata;
    if (s_we && !s_clash) mem[s_widx][{s_lane, 3'b000} +: 8] <= s_wbyte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_rword <= '0;
      s_rword <= '0;
    end else begin
      if (h_re) h_rword <= mem[h_idx];
      if (s_re) s_rword <= mem[s_widx];
    end
  end
endmodule

// File: rtl/xfb_host_if.sv
module xfb_host_if
  import xfb_pkg::*;
#(
  parameter int PTR_W  = 7,
  parameter int BPTR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [31:0]       wdata,
  input  logic [31:0]       mem_rword,
  output logic              mem_we,
  output logic              mem_re,
  output logic [PTR_W-1:0]  mem_idx,
  output logic [31:0]       rdata,
  output logic [BPTR_W-1:0] base
);
  logic             dir_q, dir_d, inc_q, inc_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [BPTR_W-1:0] base_q, base_d;
  logic             rd_data_q, rd_data_d;
  logic [31:0]      snap_q, snap_d;
  logic             ctrl_wr, base_wr, data_wr, data_rd, data_acc, rd_any;

  always_comb begin
    ctrl_wr  = req && we && (sel == SEL_CTRL);
    base_wr  = req && we && (sel == SEL_BASE);
    data_wr  = req && we && (sel == SEL_DATA) && dir_q;
    data_rd  = req && !we && (sel == SEL_DATA);
    data_acc = data_wr || data_rd;
    rd_any   = req && !we;

    dir_d  = dir_q;
    inc_d  = inc_q;
    ptr_d  = ptr_q;
    base_d = base_q;
    if (ctrl_wr) begin
      dir_d = wdata[DIR_BIT];
      inc_d = wdata[INC_BIT];
      ptr_d = wdata[PTR_W-1:0];
    end else if (data_acc && inc_q) begin
      ptr_d = ptr_q + 1'b1;
    end
    if (base_wr) base_d = wdata[BPTR_W-1:0];

    rd_data_d = rd_data_q;
    snap_d    = snap_q;
    if (rd_any) begin
      rd_data_d = (sel == SEL_DATA);
      snap_d    = '0;
      if (sel == SEL_CTRL) begin
        snap_d[DIR_BIT]     = dir_q;
        snap_d[INC_BIT]     = inc_q;
        snap_d[PTR_W-1:0]   = ptr_q;
      end else if (sel == SEL_BASE) begin
        snap_d[BPTR_W-1:0]  = base_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q     <= 1'b0;
      inc_q     <= 1'b0;
      ptr_q     <= '0;
      base_q    <= '0;
      rd_data_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      dir_q     <= dir_d;
      inc_q     <= inc_d;
      ptr_q     <= ptr_d;
      base_q    <= base_d;
      rd_data_q <= rd_data_d;
      snap_q    <= snap_d;
    end
  end

  assign mem_we  = data_wr;
  assign mem_re  = data_rd;
  assign mem_idx = ptr_q;
  assign base    = base_q;
  assign rdata   = rd_data_q ? mem_rword : snap_q;

  // R3 R5 R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && inc_q && !ctrl_wr) |=> (ptr_q == PTR_W'($past(ptr_q) + 1'b1)));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && !(data_acc && inc_q)) |=> $stable(ptr_q));

  // R2
  ctrl_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (dir_q == $past(wdata[DIR_BIT]) && inc_q == $past(wdata[INC_BIT])));
endmodule

// File: rtl/xfb_seq_if.sv
module xfb_seq_if #(
  parameter int BPTR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rd,
  input  logic              wr,
  input  logic [BPTR_W-1:0] base,
  input  logic [31:0]       mem_rword,
  output logic              mem_we,
  output logic              mem_re,
  output logic [BPTR_W-1:0] bptr,
  output logic [7:0]        rbyte
);
  logic [BPTR_W-1:0] bptr_q, bptr_d;
  logic [1:0]        lane_q, lane_d;

  always_comb begin
    mem_we = wr && !start;
    mem_re = rd && !start;
    bptr_d = bptr_q;
    lane_d = lane_q;
    if (start) bptr_d = base;
    else if (mem_we || mem_re) bptr_d = bptr_q + 1'b1;
    if (mem_re) lane_d = bptr_q[1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bptr_q <= '0;
      lane_q <= '0;
    end else begin
      bptr_q <= bptr_d;
      lane_q <= lane_d;
    end
  end

  assign bptr  = bptr_q;
  assign rbyte = mem_rword[{lane_q, 3'b000} +: 8];

  // R7
  seq_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bptr_q == $past(base)));

  // R8 R9 R10
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || mem_re) |=> (bptr_q == BPTR_W'($past(bptr_q) + 1'b1)));
endmodule

// File: rtl/xfer_buf_port.sv
module xfer_buf_port #(
  parameter int WORDS = 128,
  localparam int PTR_W  = $clog2(WORDS),
  localparam int BPTR_W = PTR_W + 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_we,
  input  logic [1:0]  host_reg,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  input  logic        seq_start,
  input  logic        seq_rd,
  input  logic        seq_wr,
  input  logic [7:0]  seq_wbyte,
  output logic [7:0]  seq_rbyte
);
  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic              h_we, h_re, s_we, s_re;
  logic [PTR_W-1:0]  h_idx;
  logic [BPTR_W-1:0] base, bptr;
  logic [31:0]       h_rword, s_rword;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  xfb_host_if #(.PTR_W(PTR_W), .BPTR_W(BPTR_W)) u_host (
    .clk(clk), .rst_n(rst_int_n), .req(host_req), .we(host_we),
    .sel(host_reg), .wdata(host_wdata), .mem_rword(h_rword),
    .mem_we(h_we), .mem_re(h_re), .mem_idx(h_idx),
    .rdata(host_rdata), .base(base)
  );

  xfb_seq_if #(.BPTR_W(BPTR_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n), .start(seq_start), .rd(seq_rd),
    .wr(seq_wr), .base(base), .mem_rword(s_rword), .mem_we(s_we),
    .mem_re(s_re), .bptr(bptr), .rbyte(seq_rbyte)
  );

  xfb_store #(.WORDS(WORDS), .PTR_W(PTR_W), .BPTR_W(BPTR_W)) u_store (
    .clk(clk), .rst_n(rst_int_n),
    .h_we(h_we), .h_re(h_re), .h_idx(h_idx), .h_wdata(host_wdata),
    .h_rword(h_rword),
    .s_we(s_we), .s_re(s_re), .s_bptr(bptr), .s_wbyte(seq_wbyte),
    .s_rword(s_rword)
  );
endmodule

// File: tb/xfer_buf_port_test.sv
module xfer_buf_port_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [1:0]  host_reg = 2'd0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        seq_start = 1'b0, seq_rd = 1'b0, seq_wr = 1'b0;
  logic [7:0]  seq_wbyte = '0;
  logic [7:0]  seq_rbyte;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  xfer_buf_port uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [1:0] r, input logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 1; host_reg = r; host_wdata = d;
    @(negedge clk);
    host_req = 0; host_we = 0;
  endtask

  task automatic hrd(input logic [1:0] r, output logic [31:0] d);
    @(negedge clk);
    host_req = 1; host_we = 0; host_reg = r;
    @(negedge clk);
    host_req = 0;
    d = host_rdata;
  endtask

  task automatic sstart();
    @(negedge clk); seq_start = 1;
    @(negedge clk); seq_start = 0;
  endtask

  task automatic srd(output logic [7:0] b);
    @(negedge clk); seq_rd = 1;
    @(negedge clk); seq_rd = 0;
    b = seq_rbyte;
  endtask

  task automatic swr(input logic [7:0] b);
    @(negedge clk); seq_wr = 1; seq_wbyte = b;
    @(negedge clk); seq_wr = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    hrd(2'd0, d); chk("R1 ctrl", d, 32'h0);
    hrd(2'd2, d); chk("R1 base", d, 32'h0);
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    hwr(2'd0, 32'hC000_00FF);
    hrd(2'd0, d); chk("R2 readback", d, 32'hC000_007F);
    hwr(2'd0, 32'h4000_0012);
    hrd(2'd0, d); chk("R2 readback2", d, 32'h4000_0012);
  endtask

  task automatic t_fill_drain();
    logic [31:0] d;
    hwr(2'd0, 32'hC000_0004);
    hwr(2'd1, 32'h1111_AAAA);
    hwr(2'd1, 32'h2222_BBBB);
    hwr(2'd1, 32'h3333_CCCC);
    hrd(2'd0, d); chk("R3 ptr advanced", d, 32'hC000_0007);
    hwr(2'd0, 32'h4000_0004);
    hrd(2'd1, d); chk("R5 word4", d, 32'h1111_AAAA);
    hrd(2'd1, d); chk("R5 word5", d, 32'h2222_BBBB);
    hrd(2'd1, d); chk("R5 word6", d, 32'h3333_CCCC);
    hrd(2'd0, d); chk("R5 ptr after reads", d, 32'h4000_0007);
  endtask

  task automatic t_no_inc();
    logic [31:0] d;
    hwr(2'd0, 32'h0000_0005);
    hrd(2'd1, d); chk("R5 no-inc read1", d, 32'h2222_BBBB);
    hrd(2'd1, d); chk("R5 no-inc read2", d, 32'h2222_BBBB);
    hrd(2'd0, d); chk("R5 ptr held", d, 32'h0000_0005);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    hwr(2'd0, 32'h4000_0004);
    hwr(2'd1, 32'hDEAD_BEEF);
    hrd(2'd0, d); chk("R4 ptr unchanged", d, 32'h4000_0004);
    hrd(2'd1, d); chk("R4 word unchanged", d, 32'h1111_AAAA);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    hwr(2'd0, 32'hC000_007F);
    hwr(2'd1, 32'hA5A5_0127);
    hwr(2'd1, 32'h5A5A_0000);
    hrd(2'd0, d); chk("R6 ptr wrapped", d, 32'hC000_0001);
    hwr(2'd0, 32'h4000_007F);
    hrd(2'd1, d); chk("R6 word127", d, 32'hA5A5_0127);
    hrd(2'd1, d); chk("R6 word0", d, 32'h5A5A_0000);
  endtask

  task automatic t_seq_read();
    logic [31:0] d;
    logic [7:0]  b;
    hwr(2'd0, 32'h8000_000A);
    hwr(2'd1, 32'h4433_2211);
    hwr(2'd2, 32'd40);
    hrd(2'd2, d); chk("R7 base readback", d, 32'd40);
    sstart();
    srd(b); chk("R8 lane0", {24'h0, b}, 32'h11);
    srd(b); chk("R8 lane1", {24'h0, b}, 32'h22);
    srd(b); chk("R8 lane2", {24'h0, b}, 32'h33);
    srd(b); chk("R8 lane3", {24'h0, b}, 32'h44);
  endtask

  task automatic t_seq_write();
    logic [31:0] d;
    hwr(2'd2, 32'd80);
    sstart();
    swr(8'hA1); swr(8'hB2); swr(8'hC3); swr(8'hD4); swr(8'hE5);
    hwr(2'd0, 32'h4000_0014);
    hrd(2'd1, d); chk("R9 word20", d, 32'hD4C3_B2A1);
    hrd(2'd1, d); chk("R9 partial low byte", d & 32'hFF, 32'hE5);
  endtask

  task automatic t_byte_wrap();
    logic [31:0] d;
    hwr(2'd2, 32'd510);
    sstart();
    swr(8'hB0); swr(8'hB1); swr(8'hB2); swr(8'hB3);
    hwr(2'd0, 32'h4000_007F);
    hrd(2'd1, d); chk("R10 word127 top", d & 32'hFFFF_0000, 32'hB1B0_0000);
    hrd(2'd1, d); chk("R10 word0 low", d & 32'h0000_FFFF, 32'h0000_B3B2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_fill_drain();
    t_no_inc();
    t_ignored();
    t_wrap();
    t_seq_read();
    t_seq_write();
    t_byte_wrap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule